// File: doc/BRIEF.md
# Redundant Logarithmic Adder

This block adds two numbers that are each held as a pair of base-2 logarithms: one word for a positive magnitude and one for a negative magnitude. The number a pair stands for is 2^P − 2^N. Adding two such numbers never requires a logarithmic subtraction. The positive words of the two operands are combined by one Gaussian-log addition path, and the negative words by a second, identical path. Both paths run side by side, so the only nonlinear function needed is sb(z) = log2(1 + 2^z).

Each path first orders its two logs so that their difference d is nonnegative. It then classifies the operation into one of four modes: MODE_NONE (both operands are the zero code), MODE_PASS (exactly one operand is the zero code, so the other is forwarded), MODE_FAR (d is beyond the table, so the larger log is the result) and MODE_NEAR (the larger log plus a correction read from a table). The correction is sb(d) − d = log2(1 + 2^−d). The table that holds it is filled by a constant function when the design is elaborated. The mode moves through the pipeline with the data, and a case on it picks the stage-2 result.

The block streams one pair per cycle with a valid-only handshake and has a fixed latency of two cycles.

Top module: `rlns_adder`

## Requirements
- R1: Every log word is LOG_W-bit two's complement with FRAC_W fraction bits. The zero code is the word with only the top bit set (the most negative word) and marks a component that is absent. A pair (P, N) means 2^P − 2^N.
- R2: sum_pos depends only on a_pos and b_pos, and sum_neg depends only on a_neg and b_neg.
- R3: When exactly one operand of a path is the zero code, the path outputs the other operand unchanged. When both operands are the zero code, it outputs the zero code.
- R4: With both operands nonzero and d = |a − b| in code units below (FRAC_W+1)·2^FRAC_W, the result is max(a, b) + round(2^FRAC_W · log2(1 + 2^(−d/2^FRAC_W))).
- R5: Two equal nonzero operands give that operand plus exactly 2^FRAC_W, which is a doubling.
- R6: When d is at least (FRAC_W+1)·2^FRAC_W, the result is max(a, b) with no correction.
- R7: Swapping the two operands of a path does not change its result.
- R8: A result above the largest positive code saturates to that code (0 followed by all ones).
- R9: out_valid rises exactly two clock cycles after a cycle with in_valid high, and back-to-back inputs give back-to-back results in order.
- R10: During and right after reset, out_valid is 0 and both sum words hold the zero code.
- R11: While out_valid is low, sum_pos and sum_neg keep the last result, whatever the inputs do while in_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands on the a/b words are valid this cycle |
| a_pos | input | LOG_W | Positive-part log of operand A |
| a_neg | input | LOG_W | Negative-part log of operand A |
| b_pos | input | LOG_W | Positive-part log of operand B |
| b_neg | input | LOG_W | Negative-part log of operand B |
| out_valid | output | 1 | Sum words are valid this cycle |
| sum_pos | output | LOG_W | Positive-part log of the sum |
| sum_neg | output | LOG_W | Negative-part log of the sum |

## Verification
The bench builds the block with LOG_W = 12 and FRAC_W = 4, which gives an 80-entry correction table and a near/far cut-off at 80 code units. With these values, directed operands can sit on each side of the cut-off (d = 79 and d = 80). They can also drive the largest positive code, 2047, into saturation, and use negative log words whose values lie below one. Expected sums are computed in the bench from the real-valued formula of each requirement.

// File: rtl/rlns_pkg.sv
package rlns_pkg;

    // Classification made in stage 1 and carried to stage 2 of each path.
    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,   // both operands absent
        MODE_PASS = 2'd1,   // one operand absent, forward the other
        MODE_FAR  = 2'd2,   // difference beyond table: larger log wins
        MODE_NEAR = 2'd3    // larger log plus tabulated correction
    } rlns_mode_e;

endpackage

// File: rtl/rlns_sb_rom.sv
module rlns_sb_rom #(
    parameter int FRAC_W = 4,
    parameter int DEPTH  = 80,
    parameter int IDX_W  = 7,
    parameter int CORR_W = 5
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [CORR_W-1:0] corr
);

    localparam real STEP = real'(1 << FRAC_W);

    // Correction log2(1 + 2^-d) scaled to code units and rounded.
    function automatic logic [CORR_W-1:0] corr_at(input int i);
        real d;
        real v;
        d = real'(i) / STEP;
        v = $ln(1.0 + $pow(2.0, -d)) / $ln(2.0) * STEP;
        return CORR_W'($rtoi(v + 0.5));
    endfunction

    logic [CORR_W-1:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign tbl[g] = corr_at(g);
    end

    always_comb begin
        if (int'(idx) < DEPTH) corr = tbl[idx];
        else                   corr = '0;
    end

endmodule

// File: rtl/rlns_path.sv
module rlns_path
    import rlns_pkg::*;
#(
    parameter int LOG_W  = 12,
    parameter int FRAC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_en,
    input  logic             s2_en,
    input  logic [LOG_W-1:0] opa,
    input  logic [LOG_W-1:0] opb,
    output logic [LOG_W-1:0] res
);

    localparam logic [LOG_W-1:0] ZERO_CODE = {1'b1, {(LOG_W-1){1'b0}}};
    localparam logic [LOG_W-1:0] MAX_CODE  = {1'b0, {(LOG_W-1){1'b1}}};
    localparam int DIFF_W = LOG_W + 1;
    localparam int CUT    = (FRAC_W + 1) << FRAC_W;
    localparam int IDX_W  = $clog2(CUT);
    localparam int CORR_W = FRAC_W + 1;

    // ---------------- stage 1: order, difference, classify ----------------
    logic              a_zero, b_zero, a_ge;
    logic [LOG_W-1:0]  big_d, small_d;
    logic [DIFF_W-1:0] diff_d;
    logic              far_d;
    rlns_mode_e        mode_d, mode_q;
    logic [LOG_W-1:0]  big_q;
    logic [IDX_W-1:0]  idx_d, idx_q;

    always_comb begin
        a_zero  = (opa == ZERO_CODE);
        b_zero  = (opb == ZERO_CODE);
        a_ge    = ($signed(opa) >= $signed(opb));
        big_d   = a_ge ? opa : opb;
        small_d = a_ge ? opb : opa;
        diff_d  = {big_d[LOG_W-1], big_d} - {small_d[LOG_W-1], small_d};
        far_d   = (diff_d >= DIFF_W'(CUT));
        idx_d   = far_d ? '0 : diff_d[IDX_W-1:0];
        if (a_zero && b_zero) begin
            mode_d = MODE_NONE;
        end else if (a_zero || b_zero) begin
            mode_d = MODE_PASS;
            big_d  = a_zero ? opb : opa;
        end else if (far_d) begin
            mode_d = MODE_FAR;
        end else begin
            mode_d = MODE_NEAR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NONE;
            big_q  <= ZERO_CODE;
            idx_q  <= '0;
        end else if (s1_en) begin
            mode_q <= mode_d;
            big_q  <= big_d;
            idx_q  <= idx_d;
        end
    end

    // ---------------- stage 2: lookup, add, saturate ----------------
    logic [CORR_W-1:0] corr;
    logic [DIFF_W-1:0] wide;
    logic [LOG_W-1:0]  near_res, res_d;

    rlns_sb_rom #(
        .FRAC_W (FRAC_W),
        .DEPTH  (CUT),
        .IDX_W  (IDX_W),
        .CORR_W (CORR_W)
    ) u_rom (
        .idx  (idx_q),
        .corr (corr)
    );

    always_comb begin
        wide = {big_q[LOG_W-1], big_q} + {{(DIFF_W-CORR_W){1'b0}}, corr};
        if (wide[DIFF_W-1] != wide[DIFF_W-2]) near_res = MAX_CODE;
        else                                  near_res = wide[LOG_W-1:0];
    end

    always_comb begin
        unique case (mode_q)
            MODE_NONE: res_d = ZERO_CODE;
            MODE_PASS: res_d = big_q;
            MODE_FAR:  res_d = big_q;
            MODE_NEAR: res_d = near_res;
            default:   res_d = ZERO_CODE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     res <= ZERO_CODE;
        else if (s2_en) res <= res_d;
    end

endmodule

// File: rtl/rlns_adder.sv
module rlns_adder #(
    parameter int LOG_W  = 12,
    parameter int FRAC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [LOG_W-1:0] a_pos,
    input  logic [LOG_W-1:0] a_neg,
    input  logic [LOG_W-1:0] b_pos,
    input  logic [LOG_W-1:0] b_neg,
    output logic             out_valid,
    output logic [LOG_W-1:0] sum_pos,
    output logic [LOG_W-1:0] sum_neg
);

    localparam int NPATH = 2;   // index 0: positive part, 1: negative part

    logic             v1_q, v2_q;
    logic [LOG_W-1:0] opa [NPATH];
    logic [LOG_W-1:0] opb [NPATH];
    logic [LOG_W-1:0] res [NPATH];

    assign opa[0] = a_pos;
    assign opb[0] = b_pos;
    assign opa[1] = a_neg;
    assign opb[1] = b_neg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
        end else begin
            v1_q <= in_valid;
            v2_q <= v1_q;
        end
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        rlns_path #(
            .LOG_W  (LOG_W),
            .FRAC_W (FRAC_W)
        ) u_path (
            .clk   (clk),
            .rst_n (rst_n),
            .s1_en (in_valid),
            .s2_en (v1_q),
            .opa   (opa[p]),
            .opb   (opb[p]),
            .res   (res[p])
        );
    end

    assign out_valid = v2_q;
    assign sum_pos   = res[0];
    assign sum_neg   = res[1];

endmodule

// File: rtl/rlns_adder_chk.sv
module rlns_adder_chk #(
    parameter int LOG_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [LOG_W-1:0] a_pos,
    input logic [LOG_W-1:0] a_neg,
    input logic [LOG_W-1:0] b_pos,
    input logic [LOG_W-1:0] b_neg,
    input logic             out_valid,
    input logic [LOG_W-1:0] sum_pos,
    input logic [LOG_W-1:0] sum_neg
);

    localparam logic [LOG_W-1:0] ZC = {1'b1, {(LOG_W-1){1'b0}}};

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid, 2) |-> out_valid);                                  // R9
    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid, 2) |-> !out_valid);                                // R9
    AST_PASS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(b_pos == ZC, 2)) |-> sum_pos == $past(a_pos, 2)); // R3
    AST_NONE_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(a_neg == ZC && b_neg == ZC, 2)) |-> sum_neg == ZC); // R3
    AST_NOT_BELOW_POS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(a_pos != ZC && b_pos != ZC, 2))
            |-> $signed(sum_pos) >= $signed($past(a_pos, 2)));              // R4
    AST_HOLD_POS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(sum_pos));                                   // R11
    AST_HOLD_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(sum_neg));                                   // R11

endmodule

bind rlns_adder rlns_adder_chk #(.LOG_W(LOG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_pos     (a_pos),
    .a_neg     (a_neg),
    .b_pos     (b_pos),
    .b_neg     (b_neg),
    .out_valid (out_valid),
    .sum_pos   (sum_pos),
    .sum_neg   (sum_neg)
);

// File: tb/rlns_adder_tb.sv
module rlns_adder_tb;

    localparam int LW  = 12;
    localparam int FW  = 4;
    localparam int CUT = (FW + 1) << FW;
    localparam logic [LW-1:0] ZC  = 12'h800;
    localparam logic [LW-1:0] MAX = 12'h7FF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [LW-1:0] a_pos = ZC, a_neg = ZC, b_pos = ZC, b_neg = ZC;
    logic          out_valid;
    logic [LW-1:0] sum_pos, sum_neg;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 8 ns period

    rlns_adder #(.LOG_W(LW), .FRAC_W(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos), .b_neg(b_neg),
        .out_valid(out_valid), .sum_pos(sum_pos), .sum_neg(sum_neg)
    );

    // Expected path result straight from the requirement formulas.
    function automatic logic [LW-1:0] ref_add(input logic [LW-1:0] x, input logic [LW-1:0] y);
        int xi, yi, big, d, r;
        real c;
        if (x == ZC && y == ZC) return ZC;
        if (x == ZC) return y;
        if (y == ZC) return x;
        xi  = int'($signed(x));
        yi  = int'($signed(y));
        big = (xi > yi) ? xi : yi;
        d   = (xi > yi) ? xi - yi : yi - xi;
        if (d >= CUT) return LW'(big);
        c = $ln(1.0 + $pow(2.0, -real'(d) / 16.0)) / $ln(2.0) * 16.0;
        r = big + $rtoi(c + 0.5);
        if (r > 2047) r = 2047;
        return LW'(r);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [LW-1:0] ap, an, bp, bn);
        a_pos = ap; a_neg = an; b_pos = bp; b_neg = bn;
        in_valid = 1'b1;
    endtask

    // One operation: drive, check latency, check both sums.
    task automatic run_op(input string req, input logic [LW-1:0] ap, an, bp, bn);
        @(negedge clk);
        drive(ap, an, bp, bn);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid low after one cycle (R9)"}, int'(out_valid), 0);
        @(negedge clk);
        chk({req, " valid after two cycles (R9)"}, int'(out_valid), 1);
        chk({req, " pos"}, int'(sum_pos), int'(ref_add(ap, bp)));
        chk({req, " neg"}, int'(sum_neg), int'(ref_add(an, bn)));
    endtask

    task automatic t_reset;
        chk("R10 valid in reset", int'(out_valid), 0);
        chk("R10 pos zero code", int'(sum_pos), int'(ZC));
        chk("R10 neg zero code", int'(sum_neg), int'(ZC));
    endtask

    task automatic t_encoding;
        real v;
        // R1: (P=32, N=16) stands for 2^2 - 2^1 = 2
        run_op("R1", 12'd32, ZC, ZC, 12'd16);
        v = $pow(2.0, real'($signed(sum_pos)) / 16.0) - $pow(2.0, real'($signed(sum_neg)) / 16.0);
        chk("R1 decoded value", $rtoi(v * 100.0 + 0.5), 200);
    endtask

    task automatic t_equal;
        run_op("R5 equal", 12'd32, 12'd100, 12'd32, 12'd100);
        chk("R5 doubling pos", int'(sum_pos), 48);
        chk("R5 doubling neg", int'(sum_neg), 116);
    endtask

    task automatic t_near;
        run_op("R4 near", 12'd100, 12'hFD8, 12'd90, 12'hFC4);
        run_op("R4 boundary d=79", 12'd300, ZC, 12'd221, ZC);
        chk("R4 d=79 gets +1", int'(sum_pos), 301);
    endtask

    task automatic t_far;
        run_op("R6 d=80", 12'd300, 12'd5, 12'd220, 12'd600);
        chk("R6 pos is larger", int'(sum_pos), 300);
        chk("R6 neg is larger", int'(sum_neg), 600);
    endtask

    task automatic t_zero;
        run_op("R3 pass", ZC, 12'd700, 12'hE0C, ZC);
        chk("R3 pos forwards b", int'(sum_pos), int'(12'hE0C));
        chk("R3 neg forwards a", int'(sum_neg), 700);
        run_op("R3 none", ZC, ZC, ZC, ZC);
        chk("R3 both absent", int'(sum_pos), int'(ZC));
    endtask

    task automatic t_swap;
        logic [LW-1:0] p1, n1;
        run_op("R7 order1", 12'd57, 12'hF00, 12'd12, 12'hF31);
        p1 = sum_pos; n1 = sum_neg;
        run_op("R7 order2", 12'd12, 12'hF31, 12'd57, 12'hF00);
        chk("R7 pos swap", int'(sum_pos), int'(p1));
        chk("R7 neg swap", int'(sum_neg), int'(n1));
    endtask

    task automatic t_sat;
        run_op("R8 sat", 12'd2040, 12'd2047, 12'd2040, 12'd2000);
        chk("R8 pos clamps", int'(sum_pos), 2047);
        chk("R8 neg clamps", int'(sum_neg), 2047);
    endtask

    task automatic t_indep;
        logic [LW-1:0] n1;
        run_op("R2 a", 12'd10, 12'd64, 12'd20, 12'd70);
        n1 = sum_neg;
        run_op("R2 b", 12'd900, 12'd64, ZC, 12'd70);
        chk("R2 neg unaffected by pos", int'(sum_neg), int'(n1));
    endtask

    task automatic t_stream;
        logic [LW-1:0] sp [4];
        logic [LW-1:0] sn [4];
        for (int k = 0; k < 4; k++) begin
            sp[k] = LW'(16 * k + 5);
            sn[k] = LW'(200 - 7 * k);
        end
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                chk("R9 stream valid", int'(out_valid), 1);
                chk("R9 stream pos", int'(sum_pos), int'(ref_add(sp[k-2], sn[k-2])));
                chk("R9 stream neg", int'(sum_neg), int'(ref_add(sn[k-2], ZC)));
            end
            if (k < 4) drive(sp[k], sn[k], sn[k], ZC);
            else       in_valid = 1'b0;
        end
    endtask

    task automatic t_hold;
        logic [LW-1:0] p1, n1;
        run_op("R11 base", 12'd40, 12'd41, 12'd42, 12'd43);
        p1 = sum_pos; n1 = sum_neg;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            a_pos = LW'(k * 300); b_pos = LW'(k * 11); a_neg = ZC; b_neg = LW'(k);
        end
        chk("R11 valid stays low", int'(out_valid), 0);
        chk("R11 pos held", int'(sum_pos), int'(p1));
        chk("R11 neg held", int'(sum_neg), int'(n1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_encoding();
        t_equal();
        t_near();
        t_far();
        t_zero();
        t_swap();
        t_sat();
        t_indep();
        t_stream();
        t_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule